// File: doc/BRIEF.md
# Four-Way Handshake Responder

This block is the destination-station half of a four-step transfer on a shared, synchronously clocked serial bus. The steps run in a fixed order. The originator sends a scout. This station answers with an acknowledgement. The originator then sends its data frame, and this station closes the transfer with a second acknowledgement. Framing, CRC and the line driver belong to neighbouring receiver and transmitter blocks.

The receiver delivers frames to this block as a start strobe, a stream of byte strobes and an end strobe. The end strobe carries a CRC verdict and arrives in a cycle after the last byte. The local station and network numbers are static configuration inputs. A frame only counts as part of the exchange when its address and, for the data frame, its originator match.

The bus leaves a very short turnaround window, so the reply cannot be built after the frame ends. The four acknowledgement bytes are therefore staged while the scout header is still arriving. The transmit request then fires on the first bus bit tick after the end strobe. Data payload bytes are streamed to a host interface as they arrive, and the host is told whether the transfer closed or failed.

Top module: `handshake_responder`

## Requirements
- R1: After reset, tx_req, host_scout_vld, host_data_vld, host_xfer_ok and host_xfer_fail are all low.
- R2: A scout is accepted when all of the following hold. It is exactly 6 bytes long, ordered destination station, destination network, source station, source network, control, port. Its CRC verdict is good. Its destination station and network equal cfg_station and cfg_network. On acceptance, host_scout_vld pulses for one cycle in the cycle after rx_end. In the same cycle, host_ctrl, host_port, host_orig_station and host_orig_network take the scout's control, port and source bytes.
- R3: A scout that fails R2 causes no scout pulse and no tx_req, even after further bus ticks. Failing cases are a wrong destination station, a wrong destination network, a bad CRC verdict and a length other than 6.
- R4: After an accepted frame, tx_req stays low until the first bus_tick following rx_end. It then pulses for exactly one cycle, in the cycle after that tick. This lies within TURN_BITS bus ticks of the frame end.
- R5: tx_ack_bytes holds the acknowledgement in send order. Bits [7:0] are the originator station and [15:8] the originator network. Bits [23:16] are cfg_station and [31:24] are cfg_network. It is valid in the cycle after the scout's fourth byte, before rx_end.
- R6: After the first acknowledgement, a data frame closes the transfer when all of the following hold. It has at least 4 bytes. Its header has destination equal to the configuration and source equal to the latched originator. Its CRC verdict is good. The closing tx_req follows R4, and host_xfer_ok pulses in the same cycle as that tx_req.
- R7: Data-frame bytes from the fifth onward appear on host_data, with host_data_vld high for one cycle, in the cycle after their rx_byte_vld. This applies only while the header matches.
- R8: A data frame with a bad CRC or a foreign source causes a host_xfer_fail pulse in the cycle after rx_end. No closing tx_req follows, and the block returns to idle, so a new scout is then accepted.
- R9: If no rx_start arrives within TIMEOUT_BITS bus ticks after the first tx_req, host_xfer_fail pulses and the block returns to idle. A data frame starting after TIMEOUT_BITS-1 ticks is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | One-cycle strobe per bus bit period |
| cfg_station | input | 8 | Local station number |
| cfg_network | input | 8 | Local network number |
| rx_start | input | 1 | Frame start strobe from the receiver |
| rx_byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Frame end strobe |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_end |
| tx_req | output | 1 | One-cycle request to send the staged acknowledgement |
| tx_ack_bytes | output | 32 | Staged acknowledgement, byte 0 in bits [7:0] |
| host_scout_vld | output | 1 | Accepted-scout pulse |
| host_ctrl | output | 8 | Control byte of the accepted scout |
| host_port | output | 8 | Port byte of the accepted scout |
| host_orig_station | output | 8 | Originator station |
| host_orig_network | output | 8 | Originator network |
| host_data_vld | output | 1 | Payload byte strobe |
| host_data | output | 8 | Payload byte |
| host_xfer_ok | output | 1 | Transfer closed pulse |
| host_xfer_fail | output | 1 | Transfer failed pulse |

## Verification
The scout pulse, the fail pulse and each payload byte are due one clock after the strobe that causes them. tx_req is due one clock after the first bus tick that follows the end strobe. A timeout fail is due two clocks after the bus tick that completes the count. The bench drives every strobe on a falling edge and samples outputs on the falling edge where each result is due. It also checks that tx_req is still low just before the launching tick, and reads the staged acknowledgement right after the fourth header byte.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCOUT,
    ST_ACK1,
    ST_WAIT,
    ST_DATA,
    ST_ACK2
  } hsr_state_e;

  typedef struct packed {
    logic [7:0] net;
    logic [7:0] stn;
  } hsr_addr_t;

  localparam int HDR_LEN   = 4;
  localparam int SCOUT_LEN = 6;
  localparam int NFIELD    = 6;
endpackage

// File: rtl/hsr_rx_parser.sv
module hsr_rx_parser
  import hsr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  input  logic             rx_end,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output hsr_addr_t        dst,
  output hsr_addr_t        src,
  output logic [7:0]       ctrl,
  output logic [7:0]       port
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       fld_q [NFIELD];

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (rx_start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (rx_end) begin
      active_d = 1'b0;
    end else if (active_q && rx_byte_vld && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    logic fld_en;
    assign fld_en = active_q && rx_byte_vld && !rx_start && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fld_q[g] <= '0;
      else if (fld_en) fld_q[g] <= rx_byte;
    end
  end

  assign active  = active_q;
  assign count   = cnt_q;
  assign dst.stn = fld_q[0];
  assign dst.net = fld_q[1];
  assign src.stn = fld_q[2];
  assign src.net = fld_q[3];
  assign ctrl    = fld_q[4];
  assign port    = fld_q[5];

  // R2: a long frame saturates the byte count instead of wrapping to a small length
  a_r2_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && rx_byte_vld && !rx_start && !rx_end && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/hsr_bit_timer.sv
module hsr_bit_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                          cnt_d = '0;
    else if (run && tick && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LIM);

  // R9: the tick count never runs past the timeout limit
  a_r9_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LIM && !start) |=> (cnt_q == LIM));
endmodule

// File: rtl/hsr_ctrl.sv
module hsr_ctrl
  import hsr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TURN_BITS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  hsr_addr_t        cfg_addr,
  input  logic             rx_start,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  input  logic             rx_end,
  input  logic             rx_crc_ok,
  input  logic             p_active,
  input  logic [CNT_W-1:0] p_count,
  input  hsr_addr_t        p_dst,
  input  hsr_addr_t        p_src,
  input  logic [7:0]       p_ctrl,
  input  logic [7:0]       p_port,
  input  logic             t_expired,
  output logic             t_start,
  output logic             t_run,
  output logic             tx_req,
  output logic [31:0]      tx_ack_bytes,
  output logic             host_scout_vld,
  output logic [7:0]       host_ctrl,
  output logic [7:0]       host_port,
  output hsr_addr_t        host_orig,
  output logic             host_data_vld,
  output logic [7:0]       host_data,
  output logic             host_xfer_ok,
  output logic             host_xfer_fail
);
  localparam logic [CNT_W-1:0] LEN_HDR   = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] LEN_SCOUT = CNT_W'(SCOUT_LEN);
  localparam logic [CNT_W-1:0] IDX_SNET  = CNT_W'(HDR_LEN - 1);
  localparam int               TW        = $clog2(TURN_BITS + 2);

  hsr_state_e  state_q, state_d;
  logic        tx_fire, scout_fire, ok_fire, fail_fire;
  logic        stage_ld, orig_ld, dv_fire;
  logic        dst_match, hdr_ok;
  logic        tx_req_q, scout_q, ok_q, fail_q, dv_q;
  logic [7:0]  dbyte_q, ctrl_q, port_q;
  logic [31:0] stage_q;
  hsr_addr_t   orig_q;

  assign dst_match = (p_dst == cfg_addr);
  assign hdr_ok    = dst_match && (p_src == orig_q);

  always_comb begin
    state_d    = state_q;
    tx_fire    = 1'b0;
    scout_fire = 1'b0;
    ok_fire    = 1'b0;
    fail_fire  = 1'b0;
    stage_ld   = 1'b0;
    orig_ld    = 1'b0;
    t_start    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rx_start) state_d = ST_SCOUT;
      end
      ST_SCOUT: begin
        if (p_active && rx_byte_vld && !rx_start && p_count == IDX_SNET) stage_ld = 1'b1;
        if (rx_end && !rx_start) begin
          if (rx_crc_ok && p_count == LEN_SCOUT && dst_match) begin
            state_d    = ST_ACK1;
            scout_fire = 1'b1;
            orig_ld    = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_ACK1: begin
        if (bus_tick) begin
          tx_fire = 1'b1;
          t_start = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rx_start) begin
          state_d = ST_DATA;
        end else if (t_expired) begin
          fail_fire = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_DATA: begin
        if (rx_end && !rx_start) begin
          if (rx_crc_ok && p_count >= LEN_HDR && hdr_ok) begin
            state_d = ST_ACK2;
          end else begin
            fail_fire = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_ACK2: begin
        if (bus_tick) begin
          tx_fire = 1'b1;
          ok_fire = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign t_run   = (state_q == ST_WAIT);
  assign dv_fire = (state_q == ST_DATA) && p_active && rx_byte_vld && !rx_start
                   && (p_count >= LEN_HDR) && hdr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tx_req_q <= 1'b0;
      scout_q  <= 1'b0;
      ok_q     <= 1'b0;
      fail_q   <= 1'b0;
      dv_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_req_q <= tx_fire;
      scout_q  <= scout_fire;
      ok_q     <= ok_fire;
      fail_q   <= fail_fire;
      dv_q     <= dv_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dbyte_q <= '0;
    else if (dv_fire)  dbyte_q <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_ld) stage_q <= {cfg_addr.net, cfg_addr.stn, rx_byte, p_src.stn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_q <= '0;
      ctrl_q <= '0;
      port_q <= '0;
    end else if (orig_ld) begin
      orig_q <= p_src;
      ctrl_q <= p_ctrl;
      port_q <= p_port;
    end
  end

  // deadline watch: bus ticks seen while a reply is pending
  logic [TW-1:0] turn_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) turn_q <= '0;
    else if (state_q != ST_ACK1 && state_q != ST_ACK2) turn_q <= '0;
    else if (bus_tick) turn_q <= turn_q + 1'b1;
  end

  assign tx_req         = tx_req_q;
  assign tx_ack_bytes   = stage_q;
  assign host_scout_vld = scout_q;
  assign host_ctrl      = ctrl_q;
  assign host_port      = port_q;
  assign host_orig      = orig_q;
  assign host_data_vld  = dv_q;
  assign host_data      = dbyte_q;
  assign host_xfer_ok   = ok_q;
  assign host_xfer_fail = fail_q;

  // R4: a pending reply is launched on the first bus tick
  a_r4_launch_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ACK1 || state_q == ST_ACK2) && bus_tick) |=> tx_req_q);
  // R4: the reply never waits longer than the turnaround window
  a_r4_turn_window: assert property (@(posedge clk) disable iff (!rst_n)
    turn_q <= TW'(TURN_BITS));
  // R4: no request without a pending reply
  a_r4_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_q |-> ($past(state_q) == ST_ACK1 || $past(state_q) == ST_ACK2));
  // R6: the closing reply is only armed by a frame with a good CRC verdict
  a_r6_final_needs_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK2 && $past(state_q) != ST_ACK2) |-> $past(rx_end && rx_crc_ok));
  // R5: the staged acknowledgement matches the latched originator while a reply is pending
  a_r5_stage_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK1) |-> (stage_q == {cfg_addr.net, cfg_addr.stn, orig_q.net, orig_q.stn}));
endmodule

// File: rtl/handshake_responder.sv
module handshake_responder
  import hsr_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int TURN_BITS    = 14,
  parameter int TIMEOUT_BITS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_tick,
  input  logic [7:0]  cfg_station,
  input  logic [7:0]  cfg_network,
  input  logic        rx_start,
  input  logic        rx_byte_vld,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  input  logic        rx_crc_ok,
  output logic        tx_req,
  output logic [31:0] tx_ack_bytes,
  output logic        host_scout_vld,
  output logic [7:0]  host_ctrl,
  output logic [7:0]  host_port,
  output logic [7:0]  host_orig_station,
  output logic [7:0]  host_orig_network,
  output logic        host_data_vld,
  output logic [7:0]  host_data,
  output logic        host_xfer_ok,
  output logic        host_xfer_fail
);
  hsr_addr_t        cfg_addr, p_dst, p_src, orig;
  logic             p_active, t_start, t_run, t_expired;
  logic [CNT_W-1:0] p_count;
  logic [7:0]       p_ctrl, p_port;

  assign cfg_addr.stn = cfg_station;
  assign cfg_addr.net = cfg_network;

  hsr_rx_parser #(.CNT_W(CNT_W)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .rx_start(rx_start), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_end(rx_end),
    .active(p_active), .count(p_count), .dst(p_dst), .src(p_src),
    .ctrl(p_ctrl), .port(p_port)
  );

  hsr_bit_timer #(.LIMIT(TIMEOUT_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .run(t_run), .tick(bus_tick),
    .expired(t_expired)
  );

  hsr_ctrl #(.CNT_W(CNT_W), .TURN_BITS(TURN_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .cfg_addr(cfg_addr),
    .rx_start(rx_start), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
    .p_active(p_active), .p_count(p_count), .p_dst(p_dst), .p_src(p_src),
    .p_ctrl(p_ctrl), .p_port(p_port),
    .t_expired(t_expired), .t_start(t_start), .t_run(t_run),
    .tx_req(tx_req), .tx_ack_bytes(tx_ack_bytes),
    .host_scout_vld(host_scout_vld), .host_ctrl(host_ctrl), .host_port(host_port),
    .host_orig(orig), .host_data_vld(host_data_vld), .host_data(host_data),
    .host_xfer_ok(host_xfer_ok), .host_xfer_fail(host_xfer_fail)
  );

  assign host_orig_station = orig.stn;
  assign host_orig_network = orig.net;

  // R1: host pulses are never asserted together
  a_r1_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_scout_vld, host_xfer_ok, host_xfer_fail}));
endmodule

// File: tb/handshake_responder_test.sv
`timescale 1ns/1ps
module handshake_responder_test;
  localparam int TMO = 64;
  localparam logic [7:0] MY_STN = 8'h2A;
  localparam logic [7:0] MY_NET = 8'h05;

  logic        clk, rst_n, bus_tick;
  logic [7:0]  cfg_station, cfg_network;
  logic        rx_start, rx_byte_vld, rx_end, rx_crc_ok;
  logic [7:0]  rx_byte;
  logic        tx_req, host_scout_vld, host_data_vld, host_xfer_ok, host_xfer_fail;
  logic [31:0] tx_ack_bytes;
  logic [7:0]  host_ctrl, host_port, host_orig_station, host_orig_network, host_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  handshake_responder #(.TIMEOUT_BITS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
    .cfg_station(cfg_station), .cfg_network(cfg_network),
    .rx_start(rx_start), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
    .tx_req(tx_req), .tx_ack_bytes(tx_ack_bytes),
    .host_scout_vld(host_scout_vld), .host_ctrl(host_ctrl), .host_port(host_port),
    .host_orig_station(host_orig_station), .host_orig_network(host_orig_network),
    .host_data_vld(host_data_vld), .host_data(host_data),
    .host_xfer_ok(host_xfer_ok), .host_xfer_fail(host_xfer_fail)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // frame buffer and observations
  logic [7:0]  fb [16];
  logic [31:0] seen_stage;
  logic        seen_scout, seen_fail, seen_tx;
  int          pay_cnt, pay_bad;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input bit crc);
    seen_tx = 0; pay_cnt = 0; pay_bad = 0; seen_stage = '0;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1'b1; rx_byte = fb[i];
      @(negedge clk);
      if (tx_req) seen_tx = 1;
      if (host_data_vld) begin
        pay_cnt++;
        if (i < 4 || host_data != fb[i]) pay_bad++;
      end
      if (i == 3) seen_stage = tx_ack_bytes;
    end
    rx_byte_vld = 1'b0; rx_end = 1'b1; rx_crc_ok = crc;
    @(negedge clk);
    rx_end = 1'b0; rx_crc_ok = 1'b0;
    seen_scout = host_scout_vld;
    seen_fail  = host_xfer_fail;
    if (tx_req) seen_tx = 1;
  endtask

  // one bus tick; returns tx_req and host_xfer_ok seen in the following cycle
  task automatic tick(output bit req, output bit okp);
    bus_tick = 1'b1;
    @(negedge clk);
    bus_tick = 1'b0;
    req = tx_req; okp = host_xfer_ok;
  endtask

  task automatic load_hdr(input logic [7:0] ds, input logic [7:0] dn,
                          input logic [7:0] ss, input logic [7:0] sn);
    fb[0] = ds; fb[1] = dn; fb[2] = ss; fb[3] = sn;
  endtask

  task automatic idle_ticks(input int k, output bit any_req);
    bit r, o;
    any_req = 0;
    for (int i = 0; i < k; i++) begin
      tick(r, o);
      if (r) any_req = 1;
    end
  endtask

  // accepted scout from 0x11/0x03, first ACK launched
  task automatic open_exchange();
    bit r, o;
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03); fb[4] = 8'h80; fb[5] = 8'h99;
    send_frame(6, 1'b1);
    tick(r, o);
  endtask

  task automatic t_reset();
    chk(!tx_req && !host_scout_vld && !host_data_vld && !host_xfer_ok && !host_xfer_fail,
        "R1 reset outputs", {tx_req, host_scout_vld, host_data_vld, host_xfer_ok, host_xfer_fail}, 0);
  endtask

  task automatic t_full_exchange();
    bit r, o;
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03); fb[4] = 8'h80; fb[5] = 8'h99;
    send_frame(6, 1'b1);
    chk(seen_stage == {MY_NET, MY_STN, 8'h03, 8'h11}, "R5 staged before end", seen_stage,
        {MY_NET, MY_STN, 8'h03, 8'h11});
    chk(seen_scout, "R2 scout pulse", seen_scout, 1);
    chk(host_ctrl == 8'h80 && host_port == 8'h99 && host_orig_station == 8'h11 &&
        host_orig_network == 8'h03, "R2 scout fields",
        {host_ctrl, host_port, host_orig_station, host_orig_network}, 32'h80991103);
    @(negedge clk); @(negedge clk);
    chk(!tx_req && !seen_tx, "R4 no request before tick", tx_req, 0);
    tick(r, o);
    chk(r, "R4 first ack request", r, 1);
    @(negedge clk);
    chk(!tx_req, "R4 request is one cycle", tx_req, 0);
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03);
    for (int i = 4; i < 9; i++) fb[i] = 8'(8'h40 + i);
    send_frame(9, 1'b1);
    chk(pay_cnt == 5 && pay_bad == 0, "R7 payload stream", pay_cnt, 5);
    chk(!seen_fail && !seen_tx, "R6 no fail or early request", {seen_fail, seen_tx}, 0);
    tick(r, o);
    chk(r && o, "R6 final ack and ok pulse", {r, o}, 2'b11);
    chk(tx_ack_bytes == {MY_NET, MY_STN, 8'h03, 8'h11}, "R5 final ack bytes", tx_ack_bytes,
        {MY_NET, MY_STN, 8'h03, 8'h11});
  endtask

  task automatic t_ignore_scouts();
    bit any;
    load_hdr(8'h2B, MY_NET, 8'h11, 8'h03); fb[4] = 8'h80; fb[5] = 8'h99;
    send_frame(6, 1'b1); idle_ticks(3, any);
    chk(!seen_scout && !any, "R3 other station ignored", {seen_scout, any}, 0);
    load_hdr(MY_STN, 8'h06, 8'h11, 8'h03);
    send_frame(6, 1'b1); idle_ticks(3, any);
    chk(!seen_scout && !any, "R3 other network ignored", {seen_scout, any}, 0);
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03);
    send_frame(6, 1'b0); idle_ticks(3, any);
    chk(!seen_scout && !any, "R3 bad crc scout ignored", {seen_scout, any}, 0);
    send_frame(5, 1'b1); idle_ticks(3, any);
    chk(!seen_scout && !any, "R3 short scout ignored", {seen_scout, any}, 0);
    send_frame(7, 1'b1); idle_ticks(3, any);
    chk(!seen_scout && !any, "R3 long scout ignored", {seen_scout, any}, 0);
  endtask

  task automatic t_bad_data();
    bit any;
    open_exchange();
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03); fb[4] = 8'h01; fb[5] = 8'h02;
    send_frame(6, 1'b0); idle_ticks(3, any);
    chk(seen_fail && !any, "R8 bad crc data rejected", {seen_fail, any}, 2'b10);
    open_exchange();
    load_hdr(MY_STN, MY_NET, 8'h12, 8'h03);
    send_frame(6, 1'b1); idle_ticks(3, any);
    chk(seen_fail && !any && pay_cnt == 0, "R8 foreign source rejected",
        {seen_fail, any, 8'(pay_cnt)}, 10'h200);
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03); fb[4] = 8'h80; fb[5] = 8'h99;
    send_frame(6, 1'b1);
    chk(seen_scout, "R8 idle again after reject", seen_scout, 1);
    idle_ticks(1, any);
    idle_ticks(TMO, any);
    @(negedge clk);
  endtask

  task automatic t_timeout();
    bit r, o, any;
    open_exchange();
    idle_ticks(TMO - 1, any);
    load_hdr(MY_STN, MY_NET, 8'h11, 8'h03); fb[4] = 8'h55;
    send_frame(5, 1'b1);
    tick(r, o);
    chk(!seen_fail && r && o, "R9 start at limit minus one accepted", {seen_fail, r, o}, 3'b011);
    open_exchange();
    idle_ticks(TMO, any);
    @(negedge clk);
    chk(host_xfer_fail, "R9 timeout fail pulse", host_xfer_fail, 1);
    send_frame(5, 1'b1);
    idle_ticks(3, any);
    chk(!any && !seen_fail, "R9 late data ignored", {any, seen_fail}, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_tick = 1'b0; rx_start = 1'b0; rx_byte_vld = 1'b0;
    rx_byte = '0; rx_end = 1'b0; rx_crc_ok = 1'b0;
    cfg_station = MY_STN; cfg_network = MY_NET;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_exchange();
    t_ignore_scouts();
    t_bad_data();
    t_timeout();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule